// File: doc/BRIEF.md
# Supply-Fail Write Guard

This block supervises a battery-backed clock and memory subsystem. External comparators deliver two flags: the supply has dropped below the power-fail level, and the supply has dropped below the battery switchover level. The block resynchronises both flags and runs a four-state sequencer. From that it drives five signals: a system reset, an active-low chip enable for the external memory, an inhibit for the internal clock registers, a main/battery source select, and an output enable for the interface pins.

While the supply is bad, register access is locked, reset is held, and the memory enable is forced inactive. Below the switchover level, the source select moves to battery and the interface pins are released. Once both flags have cleared, protection stays in force for `REC_CYCLES` clock cycles. Outside protection, the bus-side chip-enable request reaches the memory unchanged.

Top module: `supply_guard`

## Requirements
- R1: Each flag passes through two flip-flops. A power-fail flag held across two rising edges makes `reg_lock` read 1 after the second of them.
- R2: `sys_rst_o` is 1 and `mem_ce_n` is 1 in every cycle in which `reg_lock` is 1.
- R3: A switchover flag without the power-fail flag protects the block exactly as a power-fail does.
- R4: After the switchover flag rises, `on_batt` reads 1 after the third rising edge. `pins_oe` is 0 exactly while `on_batt` is 1.
- R5: When the switchover flag clears while the power-fail flag stays set, `on_batt` returns to 0 and `pins_oe` returns to 1. Reset, lock and memory inhibit stay at 1.
- R6: Both flags clear before rising edge 1. Protection still holds after edge 2+`REC_CYCLES` and is lifted after edge 3+`REC_CYCLES`.
- R7: Any flag seen during the recovery interval sends the block back to protection. The full interval restarts once the flags clear.
- R8: A flag may be seen on the same edge at which the recovery interval would finish. The flag wins, and a complete new interval follows.
- R9: Outside protection, `mem_ce_n` equals `ce_req_n` in the same cycle.
- R10: While `rst_n` is 0, the outputs read reset 1, memory enable 1 (inactive), lock 1, battery 0 and pin enable 1. After `rst_n` rises with both flags clear, the block leaves protection after edge 3+`REC_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pf_flag | input | 1 | Supply below power-fail level (asynchronous) |
| so_flag | input | 1 | Supply below battery switchover level (asynchronous) |
| ce_req_n | input | 1 | Bus-side memory chip-enable request, active low |
| sys_rst_o | output | 1 | System reset, active high |
| mem_ce_n | output | 1 | External memory chip enable, active low |
| reg_lock | output | 1 | Clock register access inhibit |
| on_batt | output | 1 | Source select: 1 = battery, 0 = main supply |
| pins_oe | output | 1 | Interface pin output enable; 0 = high impedance |

## Verification
Two events can land on the same edge: the recovery counter reaching its last cycle, and a freshly synchronised power-fail flag arriving. The bench counts edges from the moment the flags clear. It raises a one-cycle power-fail pulse timed so that the pulse reaches the second synchronizer stage exactly as the last recovery cycle ends. The outcome is judged only at the outputs. The outputs must stay protected through the following 2+`REC_CYCLES` edges and lift one edge later. If completion took priority, the block would already be unprotected three edges after the pulse.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int REC_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_flag,
  input  logic so_flag,
  input  logic ce_req_n,
  output logic sys_rst_o,
  output logic mem_ce_n,
  output logic reg_lock,
  output logic on_batt,
  output logic pins_oe
);
  localparam int CW = $clog2(REC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

  typedef enum logic [1:0] {NORMAL, PROTECT, BATTERY, RECOVER} state_t;

  state_t state, nxt;
  logic [1:0] pf_sync, so_sync;
  logic [CW-1:0] cnt;
  logic pf_s, so_s, bad, guarded, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_sync <= 2'b11;
      so_sync <= 2'b00;
    end else begin
      pf_sync <= {pf_sync[0], pf_flag};
      so_sync <= {so_sync[0], so_flag};
    end
  end

  assign pf_s = pf_sync[1];
  assign so_s = so_sync[1];
  assign bad  = pf_s | so_s;
  assign done = (cnt == LAST);

  always_comb begin
    nxt = state;
    case (state)
      NORMAL:  if (so_s) nxt = BATTERY; else if (pf_s) nxt = PROTECT;
      PROTECT: if (so_s) nxt = BATTERY; else if (!pf_s) nxt = RECOVER;
      BATTERY: if (!so_s) nxt = PROTECT;
      RECOVER: if (so_s) nxt = BATTERY; else if (pf_s) nxt = PROTECT;
               else if (done) nxt = NORMAL;
      default: nxt = PROTECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PROTECT;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state == RECOVER && nxt == RECOVER) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  assign guarded   = (state != NORMAL) | bad;
  assign reg_lock  = guarded;
  assign sys_rst_o = guarded;
  assign mem_ce_n  = guarded | ce_req_n;
  assign on_batt   = (state == BATTERY);
  assign pins_oe   = ~on_batt;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int REC_CYCLES = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic pf_flag,
  input logic so_flag,
  input logic ce_req_n,
  input logic sys_rst_o,
  input logic mem_ce_n,
  input logic reg_lock,
  input logic on_batt,
  input logic pins_oe
);
  localparam int QW = $clog2(REC_CYCLES + 8);
  logic [1:0] live;
  logic [QW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= '0;
      quiet <= '0;
    end else begin
      if (live != 2'd3) live <= live + 1'b1;
      if (pf_flag | so_flag) quiet <= '0;
      else if (quiet != QW'(REC_CYCLES + 4)) quiet <= quiet + 1'b1;
    end
  end

  // R1
  lock_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd2 && $past(pf_flag, 2)) |-> reg_lock);
  // R2
  lock_holds_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_lock |-> (mem_ce_n && sys_rst_o));
  // R4
  batt_after_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live == 2'd3 && $past(so_flag, 3) && $past(so_flag, 2) && $past(so_flag, 1)) |-> (on_batt && !pins_oe));
  // R6
  release_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (quiet >= QW'(REC_CYCLES)));
  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_lock |-> (mem_ce_n == ce_req_n));
endmodule

bind supply_guard supply_guard_chk #(.REC_CYCLES(REC_CYCLES)) i_chk (.*);

// File: tb/test_supply_guard.sv
module test_supply_guard;
  localparam int REC = 8;

  logic clk = 1'b0, rst_n = 1'b0, pf_flag = 1'b0, so_flag = 1'b0, ce_req_n = 1'b0;
  logic sys_rst_o, mem_ce_n, reg_lock, on_batt, pins_oe;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  supply_guard #(.REC_CYCLES(REC)) i_supply_guard (.*);

  // {pf, so, ce_req_n, wait[7:0], expect {rst, ce_n, lock, batt, oe}}
  localparam logic [15:0] VEC [9] = '{
    {3'b000, 8'd20, 5'b00001},
    {3'b001, 8'd2,  5'b01001},
    {3'b100, 8'd4,  5'b11101},
    {3'b110, 8'd4,  5'b11110},
    {3'b100, 8'd4,  5'b11101},
    {3'b000, 8'd4,  5'b11101},
    {3'b000, 8'd10, 5'b00001},
    {3'b010, 8'd4,  5'b11110},
    {3'b000, 8'd20, 5'b00001}
  };
  localparam string VTAG [9] = '{"R9", "R9", "R1", "R4", "R5", "R6", "R6", "R3", "R3"};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {sys_rst_o, mem_ce_n, reg_lock, on_batt, pins_oe};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #4ms;
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(2);
    chk("R10", 5'b11101);
    rst_n = 1'b1;
    step(2 + REC); chk("R10", 5'b11101);
    step(1);       chk("R10", 5'b00001);

    for (int i = 0; i < 9; i++) begin
      {pf_flag, so_flag, ce_req_n} = VEC[i][15:13];
      step(int'(VEC[i][12:5]));
      chk(VTAG[i], VEC[i][4:0]);
    end

    // R1 timing across the synchronizer
    pf_flag = 1'b1;
    step(1); chk("R1", 5'b00001);
    step(1); chk("R1", 5'b11101);
    step(2);
    pf_flag = 1'b0;
    step(2 + REC); chk("R6", 5'b11101);
    step(1);       chk("R6", 5'b00001);

    // R7 restart
    pf_flag = 1'b1; step(4);
    pf_flag = 1'b0; step(5);
    pf_flag = 1'b1; step(3);
    pf_flag = 1'b0;
    step(2 + REC); chk("R7", 5'b11101);
    step(1);       chk("R7", 5'b00001);

    // R8 flag arrives on the completion edge
    pf_flag = 1'b1; step(4);
    pf_flag = 1'b0; step(REC);
    pf_flag = 1'b1; step(1);
    pf_flag = 1'b0;
    step(2);   chk("R8", 5'b11101);
    step(REC); chk("R8", 5'b11101);
    step(1);   chk("R8", 5'b00001);

    // R9 same-cycle pass-through
    ce_req_n = 1'b1; #1; chk("R9", 5'b01001);
    ce_req_n = 1'b0; #1; chk("R9", 5'b00001);

    // R10 reset asserted mid-operation
    step(1);
    rst_n = 1'b0; #1; chk("R10", 5'b11101);
    step(1);
    rst_n = 1'b1;
    step(3 + REC); chk("R10", 5'b00001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule